// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and a calendar in packed BCD registers. A free-running reference strobe (nominally 32.768 kHz) is divided down to one pulse per second, and each pulse advances seconds, minutes, hours, day of week, date, month and a two-digit year. Carries ripple through all fields, month lengths are honoured and February gains a 29th day in leap years. Hours can be kept in a 24-hour format or in a 12-hour format with a PM flag.

A time-of-day alarm compares four fields against the running time: seconds, minutes, hours and day of week. Each field has a mask bit, so one register set gives an alarm every second, every minute, every hour, every day or once a week. A match sets an interrupt flag. An enable bit passes the flag to an active-high interrupt pin. Any read or write of an alarm register clears the flag.

Software reaches the registers through a plain synchronous address/data port. A control register holds a stop bit that freezes the clock, and it resets with the clock stopped. It also holds a write-protect bit and the interrupt enable.

Top module: `rtc_core`

## Requirements
- R1: After reset the control register reads 80h (clock stopped, no write protect, interrupt disabled). Seconds, minutes, hours and year read 00h. Day of week, date and month read 01h. All alarm registers and the status register read 00h, and irq_out is 0.
- R2: The register map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 to 10 alarm seconds/minutes/hours/day, 11 control, 12 status. A read presents data on rdata one cycle after rd_en. Bits outside each field's mask read 0. The masks are seconds/minutes/hours 7Fh, day 07h, date 3Fh, month 1Fh, year FFh, alarm sec/min/hour FFh, alarm day 87h, control C1h and status 01h. Addresses 13 to 15 read 00h.
- R3: Control bit 7 stops the clock when 1. While it is 0, one second elapses per PRESCALE cycles with ref_tick high. While it is 1, the time registers do not change except by writes, and the divider restarts from zero.
- R4: Seconds and minutes count 00 to 59 in BCD. In 24-hour mode (hours bit 6 = 0) hours count 00 to 23, and a full carry out of 23:59:59 advances the day of week and the date.
- R5: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, bits 4:0 the BCD hour) the hour runs 12, 01, ..., 11. The PM flag toggles on the 11-to-12 step, and the day advances only when 11 PM becomes 12 AM.
- R6: The date wraps to 01 after the last day of the month (30 for April, June, September and November; 31 for the others; 28 for February, or 29 when the BCD year is divisible by 4) and advances the month. December wraps to January and advances the year, the year wraps 99 to 00, and the day of week wraps 7 to 1.
- R7: When control bit 6 (write protect) is 1, writes to every register other than control are ignored. Control stays writable.
- R8: Alarm bit 7 masks that field. An unmasked field matches when bits 6:0 (bits 2:0 for the day) equal the running value. All four masked gives an alarm every second. Masking only day, hour and minute gives an alarm once a minute. Leaving all unmasked gives one alarm per week.
- R9: After each second update, a match of all unmasked fields sets the status flag (status bit 0). irq_out is registered and equals flag AND control bit 0 (interrupt enable) one cycle later.
- R10: Any read or write of addresses 7 to 10 clears the status flag, including writes blocked by write protect. A match in the same cycle wins over the clear.
- R11: A write to a time field in the same cycle as a second increment stores the written value for that field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Active-high alarm interrupt |

## Verification
The counter chain is started from preset times just before each boundary: 23:59:58 on 31 December 99, the last February day of a leap year and of a common year, 30 April, and the three critical 12-hour steps. This separates a wrong wrap value, a wrong month length, a missing leap rule and a PM toggle taken on the wrong step. The alarm is tried with all fields masked, with only seconds compared, and with every field compared once on a wrong and once on the right day of week. This separates mask handling from field comparison. A write landing on the exact increment cycle, and writes under protection, show that the right source wins a register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int AW = 4;
  localparam int DW = 8;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  // register addresses
  localparam addr_t A_SEC  = 4'd0;
  localparam addr_t A_MIN  = 4'd1;
  localparam addr_t A_HOUR = 4'd2;
  localparam addr_t A_DOW  = 4'd3;
  localparam addr_t A_DATE = 4'd4;
  localparam addr_t A_MON  = 4'd5;
  localparam addr_t A_YEAR = 4'd6;
  localparam addr_t A_ALM0 = 4'd7;
  localparam addr_t A_ALM3 = 4'd10;
  localparam addr_t A_CTRL = 4'd11;
  localparam addr_t A_STAT = 4'd12;

  localparam int N_ALM = 4;

  // storage masks
  localparam byte_t M_SEC  = 8'h7F;
  localparam byte_t M_MIN  = 8'h7F;
  localparam byte_t M_HOUR = 8'h7F;
  localparam byte_t M_DOW  = 8'h07;
  localparam byte_t M_DATE = 8'h3F;
  localparam byte_t M_MON  = 8'h1F;
  localparam byte_t M_YEAR = 8'hFF;
  localparam byte_t M_ALM  = 8'hFF;
  localparam byte_t M_ADAY = 8'h87;

  // BCD increment of a two-digit value
  function automatic byte_t bcd_inc(input byte_t v);
    byte_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'h0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // year in BCD divisible by 4: (10*tens + ones) mod 4 == (2*tens + ones) mod 4
  function automatic logic bcd_leap(input byte_t y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  // last date of a month, BCD
  function automatic byte_t month_last(input byte_t m, input logic leap);
    byte_t r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_tick,
  output logic tick_o
);

  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (ref_tick) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  wr_en,
  input  addr_t addr,
  input  byte_t wdata,
  output byte_t sec_o,
  output byte_t min_o,
  output byte_t hour_o,
  output byte_t dow_o,
  output byte_t date_o,
  output byte_t mon_o,
  output byte_t year_o,
  output logic  upd_o
);

  byte_t sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  byte_t sec_nx, min_nx, hour_nx, dow_nx, date_nx, mon_nx, year_nx;
  byte_t h_bcd, h_inc;
  logic  sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap;
  logic  en_min, en_hour, en_day, en_mon, en_year;

  // seconds and minutes
  always_comb begin
    sec_wrap = (sec_q == 8'h59);
    sec_nx   = sec_wrap ? 8'h00 : bcd_inc(sec_q);
    min_wrap = (min_q == 8'h59);
    min_nx   = min_wrap ? 8'h00 : bcd_inc(min_q);
  end

  // hours, both formats
  always_comb begin
    hour_nx   = hour_q;
    hour_wrap = 1'b0;
    if (hour_q[6]) begin
      h_bcd = {3'b000, hour_q[4:0]};
      h_inc = bcd_inc(h_bcd);
      if (h_bcd == 8'h12) begin
        hour_nx = {2'b01, hour_q[5], 5'h01};
      end else if (h_bcd == 8'h11) begin
        hour_nx   = {2'b01, ~hour_q[5], 5'h12};
        hour_wrap = hour_q[5];
      end else begin
        hour_nx = {2'b01, hour_q[5], h_inc[4:0]};
      end
    end else begin
      h_bcd = {2'b00, hour_q[5:0]};
      h_inc = bcd_inc(h_bcd);
      if (h_bcd == 8'h23) begin
        hour_nx   = 8'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nx = h_inc;
      end
    end
  end

  // calendar
  always_comb begin
    dow_nx    = (dow_q == 8'h07) ? 8'h01 : dow_q + 8'd1;
    date_wrap = (date_q == month_last(mon_q, bcd_leap(year_q)));
    date_nx   = date_wrap ? 8'h01 : bcd_inc(date_q);
    mon_wrap  = (mon_q == 8'h12);
    mon_nx    = mon_wrap ? 8'h01 : bcd_inc(mon_q);
    year_nx   = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  // carry chain enables
  always_comb begin
    en_min  = tick && sec_wrap;
    en_hour = en_min && min_wrap;
    en_day  = en_hour && hour_wrap;
    en_mon  = en_day && date_wrap;
    en_year = en_mon && mon_wrap;
  end

  function automatic logic hit(input addr_t a);
    return wr_en && (addr == a);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= tick;
      if (hit(A_SEC))       sec_q  <= wdata & M_SEC;
      else if (tick)        sec_q  <= sec_nx;
      if (hit(A_MIN))       min_q  <= wdata & M_MIN;
      else if (en_min)      min_q  <= min_nx;
      if (hit(A_HOUR))      hour_q <= wdata & M_HOUR;
      else if (en_hour)     hour_q <= hour_nx;
      if (hit(A_DOW))       dow_q  <= wdata & M_DOW;
      else if (en_day)      dow_q  <= dow_nx;
      if (hit(A_DATE))      date_q <= wdata & M_DATE;
      else if (en_day)      date_q <= date_nx;
      if (hit(A_MON))       mon_q  <= wdata & M_MON;
      else if (en_mon)      mon_q  <= mon_nx;
      if (hit(A_YEAR))      year_q <= wdata & M_YEAR;
      else if (en_year)     year_q <= year_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign dow_o  = dow_q;
  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  logic  wr_ok,
  input  logic  access,
  input  addr_t addr,
  input  byte_t wdata,
  input  byte_t sec,
  input  byte_t min,
  input  byte_t hour,
  input  byte_t dow,
  input  logic  aie,
  output logic [N_ALM-1:0][DW-1:0] alm_o,
  output logic  irqf_o,
  output logic  set_o,
  output logic  irq_o
);

  byte_t               alm_q [N_ALM];
  byte_t               cur   [N_ALM];
  logic  [N_ALM-1:0]   field_ok;

  assign cur[0] = sec;
  assign cur[1] = min;
  assign cur[2] = hour;
  assign cur[3] = dow;

  for (genvar gi = 0; gi < N_ALM; gi++) begin : g_fld
    localparam addr_t MY_ADDR = AW'(int'(A_ALM0) + gi);
    localparam byte_t MY_MASK = (gi == N_ALM - 1) ? M_ADAY : M_ALM;

    always_ff @(posedge clk) begin
      if (rst)                               alm_q[gi] <= 8'h00;
      else if (wr_ok && (addr == MY_ADDR))   alm_q[gi] <= wdata & MY_MASK;
    end

    assign field_ok[gi] = alm_q[gi][7] || (alm_q[gi][6:0] == cur[gi][6:0]);
    assign alm_o[gi]    = alm_q[gi];
  end

  assign set_o = upd && (&field_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      irqf_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (set_o)       irqf_o <= 1'b1;
      else if (access) irqf_o <= 1'b0;
      irq_o <= irqf_o && aie;
    end
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_out
);

  logic  osc_stop_q, wp_q, aie_q;
  logic  sec_tick, upd_w;
  logic  wr_ok, alm_sel, alm_acc_w;
  logic  irqf_w, set_evt_w;
  byte_t sec_w, min_w, hour_w, dow_w, date_w, mon_w, year_w;
  logic [N_ALM-1:0][DW-1:0] alm_w;
  byte_t rd_mux;

  assign wr_ok     = wr_en && !wp_q;
  assign alm_sel   = (addr >= A_ALM0) && (addr <= A_ALM3);
  assign alm_acc_w = alm_sel && (rd_en || wr_en);

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_stop_q <= 1'b1;
      wp_q       <= 1'b0;
      aie_q      <= 1'b0;
    end else if (wr_en && addr == A_CTRL) begin
      osc_stop_q <= wdata[7];
      wp_q       <= wdata[6];
      aie_q      <= wdata[0];
    end
  end

  rtc_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (!osc_stop_q),
    .ref_tick (ref_tick),
    .tick_o   (sec_tick)
  );

  rtc_timekeep u_tk (
    .clk    (clk),
    .rst    (rst),
    .tick   (sec_tick),
    .wr_en  (wr_ok),
    .addr   (addr),
    .wdata  (wdata),
    .sec_o  (sec_w),
    .min_o  (min_w),
    .hour_o (hour_w),
    .dow_o  (dow_w),
    .date_o (date_w),
    .mon_o  (mon_w),
    .year_o (year_w),
    .upd_o  (upd_w)
  );

  rtc_alarm u_alm (
    .clk    (clk),
    .rst    (rst),
    .upd    (upd_w),
    .wr_ok  (wr_ok),
    .access (alm_acc_w),
    .addr   (addr),
    .wdata  (wdata),
    .sec    (sec_w),
    .min    (min_w),
    .hour   (hour_w),
    .dow    (dow_w),
    .aie    (aie_q),
    .alm_o  (alm_w),
    .irqf_o (irqf_w),
    .set_o  (set_evt_w),
    .irq_o  (irq_out)
  );

  // read mux
  always_comb begin
    case (addr)
      A_SEC:   rd_mux = sec_w;
      A_MIN:   rd_mux = min_w;
      A_HOUR:  rd_mux = hour_w;
      A_DOW:   rd_mux = dow_w;
      A_DATE:  rd_mux = date_w;
      A_MON:   rd_mux = mon_w;
      A_YEAR:  rd_mux = year_w;
      4'd7:    rd_mux = alm_w[0];
      4'd8:    rd_mux = alm_w[1];
      4'd9:    rd_mux = alm_w[2];
      4'd10:   rd_mux = alm_w[3];
      A_CTRL:  rd_mux = {osc_stop_q, wp_q, 5'b00000, aie_q};
      A_STAT:  rd_mux = {7'b0000000, irqf_w};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_stop,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] sec,
  input logic [7:0] rdata,
  input logic       irqf,
  input logic       aie,
  input logic       irq_out,
  input logic       set_evt,
  input logic       alm_acc
);

  // R3: a clock held stopped leaves seconds unchanged unless written
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && $past(osc_stop) && $past(osc_stop, 2) && !$past(wr_en)) |-> $stable(sec));

  // R9: a match raises the flag on the next cycle
  a_r9_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> irqf);

  // R9: the pin is only high when flag and enable were both high
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(irqf && aie));

  // R10: alarm register access clears the flag when no match coincides
  a_r10_access_clears: assert property (@(posedge clk) disable iff (rst)
    (alm_acc && !set_evt) |=> !irqf);

  // R2: unused addresses read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > 4'd12) |=> (rdata == 8'h00));

endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .osc_stop (osc_stop_q),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .sec      (sec_w),
  .rdata    (rdata),
  .irqf     (irqf_w),
  .aie      (aie_q),
  .irq_out  (irq_out),
  .set_evt  (set_evt_w),
  .alm_acc  (alm_acc_w)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;

  localparam int P = 4;
  localparam logic [3:0] R_SEC = 0, R_MIN = 1, R_HR = 2, R_DOW = 3, R_DATE = 4,
                         R_MON = 5, R_YR = 6, R_AS = 7, R_AM = 8, R_AH = 9,
                         R_AD = 10, R_CTL = 11, R_ST = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ctrl_base = 8'h00;
  logic [7:0] v;

  always #5 clk = ~clk;

  rtc_core #(.PRESCALE(P)) u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(R_CTL, ctrl_base | 8'h80);
    wr(R_SEC, s); wr(R_MIN, m); wr(R_HR, h); wr(R_DOW, dw);
    wr(R_DATE, dt); wr(R_MON, mo); wr(R_YR, y);
  endtask

  task automatic run_secs(input int n);
    wr(R_CTL, ctrl_base);
    repeat (P * n - 1) @(negedge clk);
    wr(R_CTL, ctrl_base | 8'h80);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
    rd_chk("R1 ctrl", R_CTL, 8'h80);
    rd_chk("R1 sec", R_SEC, 8'h00);
    rd_chk("R1 dow", R_DOW, 8'h01);
    rd_chk("R1 date", R_DATE, 8'h01);
    rd_chk("R1 month", R_MON, 8'h01);
    rd_chk("R1 status", R_ST, 8'h00);
    rd_chk("R1 alarm day", R_AD, 8'h00);
  endtask

  task automatic t_map;
    wr(R_SEC, 8'hFF);
    rd_chk("R2 sec mask", R_SEC, 8'h7F);
    wr(R_DOW, 8'hFF);
    rd_chk("R2 dow mask", R_DOW, 8'h07);
    wr(R_AD, 8'hFF);
    rd_chk("R2 alarm day mask", R_AD, 8'h87);
    rd_chk("R2 unused addr", 4'd14, 8'h00);
    wr(R_CTL, 8'hFF);
    rd_chk("R2 ctrl mask", R_CTL, 8'hC1);
    wr(R_CTL, 8'h80);
  endtask

  task automatic t_stopped;
    wr(R_SEC, 8'h05);
    repeat (5 * P) @(negedge clk);
    rd_chk("R3 stopped sec", R_SEC, 8'h05);
    run_secs(3);
    rd_chk("R3 three seconds", R_SEC, 8'h08);
  endtask

  task automatic t_rollover;
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    run_secs(1);
    rd_chk("R4 sec 59", R_SEC, 8'h59);
    rd_chk("R4 min hold", R_MIN, 8'h59);
    run_secs(1);
    rd_chk("R4 sec wrap", R_SEC, 8'h00);
    rd_chk("R4 min wrap", R_MIN, 8'h00);
    rd_chk("R4 hour wrap", R_HR, 8'h00);
    rd_chk("R6 dow wrap", R_DOW, 8'h01);
    rd_chk("R6 date wrap", R_DATE, 8'h01);
    rd_chk("R6 month wrap", R_MON, 8'h01);
    rd_chk("R6 year wrap", R_YR, 8'h00);
  endtask

  task automatic t_months;
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    run_secs(1);
    rd_chk("R6 leap feb 29", R_DATE, 8'h29);
    rd_chk("R6 leap month", R_MON, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    run_secs(1);
    rd_chk("R6 leap to mar", R_DATE, 8'h01);
    rd_chk("R6 leap mar", R_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    run_secs(1);
    rd_chk("R6 common to mar", R_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    run_secs(1);
    rd_chk("R6 april end date", R_DATE, 8'h01);
    rd_chk("R6 april end month", R_MON, 8'h05);
  endtask

  task automatic t_12h;
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h06, 8'h23);
    run_secs(1);
    rd_chk("R5 11am to 12pm", R_HR, 8'h72);
    rd_chk("R5 noon no day step", R_DATE, 8'h10);
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h10, 8'h06, 8'h23);
    run_secs(1);
    rd_chk("R5 12pm to 1pm", R_HR, 8'h61);
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h06, 8'h23);
    run_secs(1);
    rd_chk("R5 11pm to 12am", R_HR, 8'h52);
    rd_chk("R5 midnight dow", R_DOW, 8'h04);
    rd_chk("R5 midnight date", R_DATE, 8'h11);
  endtask

  task automatic t_protect;
    wr(R_SEC, 8'h21);
    wr(R_CTL, 8'hC0);
    wr(R_SEC, 8'h33);
    wr(R_AS, 8'h44);
    rd_chk("R7 sec protected", R_SEC, 8'h21);
    rd_chk("R7 alarm protected", R_AS, 8'h00);
    wr(R_CTL, 8'h80);
    rd_chk("R7 ctrl writable", R_CTL, 8'h80);
  endtask

  task automatic t_priority;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(R_CTL, ctrl_base);
    repeat (P) @(negedge clk);
    wr(R_SEC, 8'h40);
    wr(R_CTL, ctrl_base | 8'h80);
    repeat (4) @(negedge clk);
    rd_chk("R11 write beats tick", R_SEC, 8'h40);
  endtask

  task automatic t_alarm_all;
    ctrl_base = 8'h01;
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(R_AS, 8'h80); wr(R_AM, 8'h80); wr(R_AH, 8'h80); wr(R_AD, 8'h80);
    run_secs(1);
    chk("R8 every second irq", {7'b0, irq_out}, 8'h01);
    rd_chk("R9 flag set", R_ST, 8'h01);
    rd(R_AM, v);
    @(negedge clk); @(negedge clk);
    chk("R10 read clears irq", {7'b0, irq_out}, 8'h00);
    rd_chk("R10 read clears flag", R_ST, 8'h00);
  endtask

  task automatic t_alarm_min;
    ctrl_base = 8'h01;
    set_time(8'h28, 8'h05, 8'h03, 8'h02, 8'h01, 8'h01, 8'h00);
    wr(R_AS, 8'h30); wr(R_AM, 8'h80); wr(R_AH, 8'h80); wr(R_AD, 8'h80);
    run_secs(1);
    rd_chk("R8 seconds mismatch", R_ST, 8'h00);
    run_secs(1);
    rd_chk("R8 seconds match", R_ST, 8'h01);
    chk("R9 irq enabled", {7'b0, irq_out}, 8'h01);
    ctrl_base = 8'h00;
    wr(R_CTL, 8'h80);
    @(negedge clk);
    chk("R9 irq disabled", {7'b0, irq_out}, 8'h00);
    rd_chk("R9 flag kept", R_ST, 8'h01);
    wr(R_CTL, 8'hC0);
    wr(R_AS, 8'h00);
    wr(R_CTL, 8'h80);
    rd_chk("R10 blocked write clears", R_ST, 8'h00);
  endtask

  task automatic t_alarm_week;
    ctrl_base = 8'h01;
    wr(R_AS, 8'h00); wr(R_AM, 8'h00); wr(R_AH, 8'h08); wr(R_AD, 8'h03);
    set_time(8'h59, 8'h59, 8'h07, 8'h02, 8'h01, 8'h01, 8'h00);
    run_secs(1);
    rd_chk("R8 weekly wrong day", R_ST, 8'h00);
    set_time(8'h59, 8'h59, 8'h07, 8'h03, 8'h01, 8'h01, 8'h00);
    run_secs(1);
    rd_chk("R8 weekly match", R_ST, 8'h01);
    ctrl_base = 8'h00;
    wr(R_CTL, 8'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_map;
    t_stopped;
    t_rollover;
    t_months;
    t_12h;
    t_protect;
    t_priority;
    t_alarm_all;
    t_alarm_min;
    t_alarm_week;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule